// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Gate

This block sits between decode and execute of a statically scheduled two-wide pipeline. Each cycle it receives one aligned two-instruction packet. The packet arrives as two pre-decoded descriptors. The first slot feeds the arithmetic/branch pipe and the second slot feeds the memory pipe. The block also receives the destination and load flag of the packet now in the execute stage. From these inputs it decides whether each slot issues in this cycle, and whether fetch must hold the packet for another cycle.

Three conditions stop a packet from issuing as a whole. A slot may hold an instruction of the wrong kind, which makes the packet illegal and nothing issues. The memory slot may read a register that the arithmetic slot of the same packet writes. In that case the packet is split: the arithmetic slot issues now and the memory slot issues one cycle later. A load in execute may write a register that a waiting instruction reads. Then everything still waiting holds for one cycle. Each of these conditions has its own output so that a counter outside the block can tally them.

A one-bit register records that the arithmetic half of a split packet has already gone. This keeps that half from issuing a second time.

Top module: `dual_issue_gate`

## Requirements
- R1: After a synchronous active-low reset, the block holds no memory of a partly issued packet. With both slots invalid, every output is 0. A dependent packet presented after reset splits again and issues its arithmetic slot first.
- R2: Class codes are 3 bits: 0 nop, 1 arithmetic, 2 branch, 3 load, 4 store, 5 to 7 reserved. The first slot accepts only arithmetic or branch with its load flag clear. The second slot accepts only a load with its load flag set, or a store with its load flag clear. Any other valid non-nop slot raises `illegal`. An illegal packet issues neither slot, and `stall`, `split` and `lu_stall` all stay 0.
- R3: A slot that is invalid or has class nop issues nothing. It neither reads nor writes registers for hazard purposes.
- R4: A legal packet with no hazard issues both of its real instructions in the same cycle, with `stall` at 0.
- R5: When the memory slot reads (on either source) the nonzero destination of the arithmetic slot, the packet splits. In the first cycle `issue_alu`, `split` and `stall` are 1 and `issue_mem` is 0. In the next cycle `issue_mem` is 1, `issue_alu` is 0 and `stall` is 0.
- R6: When execute holds a valid load whose nonzero destination is read by any instruction still waiting in the packet, no slot issues, and `lu_stall` and `stall` are 1 for that cycle.
- R7: Register 0 never causes a split or a load-use stall.
- R8: Priority runs illegal, then load-use, then split. During the second cycle of a split, only the memory slot's sources are checked against execute. The arithmetic slot never issues twice, and a split cycle is never directly followed by another split cycle.
- R9: `stall` is 1 exactly when `split` or `lu_stall` is 1. At most one of `split`, `lu_stall` and `illegal` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_valid | input | 1 | First slot holds a descriptor |
| a_cls | input | 3 | First slot class code |
| a_is_load | input | 1 | First slot load flag |
| a_dst | input | AW | First slot destination register |
| a_src1 | input | AW | First slot source register one |
| a_src2 | input | AW | First slot source register two |
| m_valid | input | 1 | Second slot holds a descriptor |
| m_cls | input | 3 | Second slot class code |
| m_is_load | input | 1 | Second slot load flag |
| m_dst | input | AW | Second slot destination register |
| m_src1 | input | AW | Second slot source register one (address base) |
| m_src2 | input | AW | Second slot source register two (store data) |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_is_load | input | 1 | Execute stage instruction is a load |
| ex_dst | input | AW | Execute stage load destination |
| issue_alu | output | 1 | First slot issues this cycle |
| issue_mem | output | 1 | Second slot issues this cycle |
| stall | output | 1 | Fetch holds the current packet |
| split | output | 1 | Intra-packet dependency; only the first slot issued |
| lu_stall | output | 1 | Load-use stall cycle |
| illegal | output | 1 | Packet has a wrong-kind slot |

## Verification
The only state in the block is the flag that marks a half-issued packet, so a wrong value of that flag shows at the ports within one cycle. If the flag is stuck clear, a split packet splits forever and reissues its arithmetic half in the very next cycle. If the flag is stuck set, or set when no split happened, an independent packet loses `issue_alu` on the cycle it arrives. If the flag is cleared early by a load-use stall in the middle of a split, the arithmetic half reissues one cycle after that stall. The sweeps walk every class pairing and every register overlap over a four-register space, and follow each split through its second cycle.

// File: rtl/dig_pkg.sv
// Shared encodings for the dual-issue packet hazard gate.
// Assumes a 3-bit class code supplied by an upstream decoder.
package dig_pkg;
    typedef enum logic [2:0] {
        CLS_NOP   = 3'd0,
        CLS_ALU   = 3'd1,
        CLS_BR    = 3'd2,
        CLS_LOAD  = 3'd3,
        CLS_STORE = 3'd4
    } op_cls_e;

    localparam int CLS_W = 3;
endpackage

// File: rtl/dig_slot_check.sv
// Legality check for one issue slot.
// IS_MEM selects the slot kind: 0 = arithmetic/branch slot, 1 = load/store slot.
// Assumes a nop (or an invalid descriptor) is always legal and inactive.
module dig_slot_check
    import dig_pkg::*;
#(
    parameter bit IS_MEM = 1'b0
) (
    input  logic             valid,
    input  logic [CLS_W-1:0] cls,
    input  logic             is_load,
    output logic             active,
    output logic             bad
);
    logic real_op;
    logic kind_ok;

    // A descriptor carries work only when valid and not a nop.
    always_comb real_op = valid && (cls != CLS_NOP);

    generate
        if (IS_MEM) begin : g_mem
            // Memory slot: a load must flag itself as a load, a store must not.
            always_comb kind_ok = ((cls == CLS_LOAD)  &&  is_load) ||
                                  ((cls == CLS_STORE) && !is_load);
        end else begin : g_alu
            // Arithmetic slot: arithmetic or branch, never flagged as a load.
            always_comb kind_ok = ((cls == CLS_ALU) || (cls == CLS_BR)) && !is_load;
        end
    endgenerate

    // Slot outcome: real and legal means active, real and wrong kind means bad.
    always_comb begin
        active = real_op && kind_ok;
        bad    = real_op && !kind_ok;
    end
endmodule

// File: rtl/dig_reg_hit.sv
// Read-after-write match of one written register against two read registers.
// Assumes register 0 is hard-wired and never carries a dependency.
module dig_reg_hit #(
    parameter int AW = 5
) (
    input  logic          en,
    input  logic [AW-1:0] wr_reg,
    input  logic [AW-1:0] rd_a,
    input  logic [AW-1:0] rd_b,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Match either read port against a nonzero written register.
    always_comb hit = en && (wr_reg != ZERO_REG) &&
                      ((rd_a == wr_reg) || (rd_b == wr_reg));
endmodule

// File: rtl/dig_split_track.sv
// Remembers that the arithmetic half of a split packet has already issued.
// Assumes fetch holds the same packet while stall is high.
module dig_split_track (
    input  logic clk,
    input  logic rst_n,
    input  logic split_now,
    input  logic lu_now,
    output logic alu_done
);
    // Set on a split, held across a load-use stall, cleared once the packet moves on.
    always_ff @(posedge clk) begin
        if (!rst_n)         alu_done <= 1'b0;
        else if (split_now) alu_done <= 1'b1;
        else if (!lu_now)   alu_done <= 1'b0;
    end
endmodule

// File: rtl/dual_issue_gate.sv
// Issue control for a statically scheduled two-wide pipeline.
// Decides per cycle which slot of the held packet issues, and flags
// illegal packets, intra-packet splits and load-use stalls.
// Assumes fetch re-presents the same packet while stall is high, and
// that a branch or nop supplies destination register 0.
module dual_issue_gate
    import dig_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_valid,
    input  logic [CLS_W-1:0] a_cls,
    input  logic             a_is_load,
    input  logic [AW-1:0]    a_dst,
    input  logic [AW-1:0]    a_src1,
    input  logic [AW-1:0]    a_src2,
    input  logic             m_valid,
    input  logic [CLS_W-1:0] m_cls,
    input  logic             m_is_load,
    input  logic [AW-1:0]    m_dst,
    input  logic [AW-1:0]    m_src1,
    input  logic [AW-1:0]    m_src2,
    input  logic             ex_valid,
    input  logic             ex_is_load,
    input  logic [AW-1:0]    ex_dst,
    output logic             issue_alu,
    output logic             issue_mem,
    output logic             stall,
    output logic             split,
    output logic             lu_stall,
    output logic             illegal
);
    localparam int NSLOT = 2;

    logic [NSLOT-1:0] slot_valid;
    logic [NSLOT-1:0] slot_load;
    logic [NSLOT-1:0] slot_act;
    logic [NSLOT-1:0] slot_bad;
    logic [NSLOT-1:0] lu_hit;
    logic [NSLOT-1:0] lu_en;
    logic [AW-1:0]    slot_rd_a [NSLOT];
    logic [AW-1:0]    slot_rd_b [NSLOT];
    logic [CLS_W-1:0] slot_cls  [NSLOT];
    logic             intra_hit;
    logic             alu_done;
    logic             ex_load;
    logic             any_bad;
    logic             m_dst_unused;

    // Gather both slots into indexed form so one generate loop covers them.
    always_comb begin
        slot_valid   = {m_valid, a_valid};
        slot_load    = {m_is_load, a_is_load};
        slot_cls[0]  = a_cls;
        slot_cls[1]  = m_cls;
        slot_rd_a[0] = a_src1;
        slot_rd_b[0] = a_src2;
        slot_rd_a[1] = m_src1;
        slot_rd_b[1] = m_src2;
    end

    // A load in execute can stall any slot that is still waiting to issue.
    always_comb begin
        ex_load  = ex_valid && ex_is_load;
        lu_en[0] = ex_load && slot_act[0] && !alu_done;
        lu_en[1] = ex_load && slot_act[1];
    end

    genvar s;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_slot
            dig_slot_check #(.IS_MEM(s == 1)) i_check (
                .valid   (slot_valid[s]),
                .cls     (slot_cls[s]),
                .is_load (slot_load[s]),
                .active  (slot_act[s]),
                .bad     (slot_bad[s])
            );

            dig_reg_hit #(.AW(AW)) i_lu (
                .en     (lu_en[s]),
                .wr_reg (ex_dst),
                .rd_a   (slot_rd_a[s]),
                .rd_b   (slot_rd_b[s]),
                .hit    (lu_hit[s])
            );
        end
    endgenerate

    // The memory slot must not consume the arithmetic slot's result in the same cycle.
    dig_reg_hit #(.AW(AW)) i_intra (
        .en     (slot_act[0] && slot_act[1] && !alu_done),
        .wr_reg (a_dst),
        .rd_a   (m_src1),
        .rd_b   (m_src2),
        .hit    (intra_hit)
    );

    dig_split_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .split_now (split),
        .lu_now    (lu_stall),
        .alu_done  (alu_done)
    );

    // The memory slot's own destination plays no part in the issue decision.
    always_comb m_dst_unused = ^m_dst;

    // Issue decision with priority illegal, then load-use, then split.
    always_comb begin
        any_bad   = |slot_bad;
        illegal   = any_bad;
        lu_stall  = !any_bad && (|lu_hit);
        split     = !any_bad && !lu_stall && intra_hit;
        issue_alu = !any_bad && !lu_stall && slot_act[0] && !alu_done;
        issue_mem = !any_bad && !lu_stall && slot_act[1] && !split;
        stall     = split || lu_stall;
    end
endmodule

// File: rtl/dual_issue_gate_chk.sv
// Port-level properties of the dual-issue gate, bound to every instance.
// Assumes a synchronous active-low reset on rst_n.
module dual_issue_gate_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] ex_dst,
    input logic          issue_alu,
    input logic          issue_mem,
    input logic          stall,
    input logic          split,
    input logic          lu_stall,
    input logic          illegal
);
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!issue_alu && !issue_mem && !stall)); // R2

    AST_FULL_ISSUE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_alu && issue_mem) |-> !stall); // R4

    AST_SPLIT_ALU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        split |-> (issue_alu && !issue_mem)); // R5

    AST_SPLIT_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        split |=> !issue_alu); // R8

    AST_SPLIT_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        split |=> !split); // R8

    AST_LOADUSE_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        lu_stall |-> (!issue_alu && !issue_mem && stall)); // R6

    AST_ZERO_REG_NO_LOADUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == '0) |-> !lu_stall); // R7

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({split, lu_stall, illegal})); // R9
endmodule

bind dual_issue_gate dual_issue_gate_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_dual_issue_gate.sv
// Sweeps class pairings and register overlaps over a four-register space.
// Expected outputs come from the requirement rules applied to a bench-side
// copy of the split-pending state.
module test_dual_issue_gate;
    localparam int AW = 5;
    localparam int WATCHDOG_CYC = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_valid = 1'b0, m_valid = 1'b0;
    logic [2:0]    a_cls = '0, m_cls = '0;
    logic          a_is_load = 1'b0, m_is_load = 1'b0;
    logic [AW-1:0] a_dst = '0, a_src1 = '0, a_src2 = '0;
    logic [AW-1:0] m_dst = '0, m_src1 = '0, m_src2 = '0;
    logic          ex_valid = 1'b0, ex_is_load = 1'b0;
    logic [AW-1:0] ex_dst = '0;
    logic          issue_alu, issue_mem, stall, split, lu_stall, illegal;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  model_done = 1'b0;
    bit  finished = 1'b0;
    bit  exp_lu, exp_split;

    always #2 clk = ~clk;

    dual_issue_gate #(.AW(AW)) i_dual_issue_gate (.*);

    function automatic bit reads(logic [AW-1:0] w, logic [AW-1:0] r1, logic [AW-1:0] r2);
        return (w != '0) && ((r1 == w) || (r2 == w));
    endfunction

    // Compare all six outputs against the rules; tag names the requirement.
    task automatic check_now(input string tag);
        bit a_real, m_real, a_ok, m_ok, bad, ia, im;
        logic [5:0] act, exp;
        a_real = a_valid && a_cls != 3'd0;
        m_real = m_valid && m_cls != 3'd0;
        a_ok   = (a_cls == 3'd1 || a_cls == 3'd2) && !a_is_load;
        m_ok   = (m_cls == 3'd3 && m_is_load) || (m_cls == 3'd4 && !m_is_load);
        bad    = (a_real && !a_ok) || (m_real && !m_ok);
        exp_lu = !bad && ex_valid && ex_is_load &&
                 ((a_real && !model_done && reads(ex_dst, a_src1, a_src2)) ||
                  (m_real && reads(ex_dst, m_src1, m_src2)));
        exp_split = !bad && !exp_lu && a_real && m_real && !model_done &&
                    reads(a_dst, m_src1, m_src2);
        ia  = !bad && !exp_lu && a_real && !model_done;
        im  = !bad && !exp_lu && m_real && !exp_split;
        exp = {ia, im, exp_split || exp_lu, exp_split, exp_lu, bad};
        act = {issue_alu, issue_mem, stall, split, lu_stall, illegal};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {alu,mem,stall,split,lu,illegal} actual %b expected %b", tag, act, exp);
        end
    endtask

    // One cycle: check just after the falling edge, then cross the rising edge.
    task automatic step(input string tag);
        #1 check_now(tag);
        if (exp_split) model_done = 1'b1;
        else if (!exp_lu) model_done = 1'b0;
        @(negedge clk);
    endtask

    // Run one packet to completion; a load-use bubble clears execute afterwards.
    task automatic run_packet(input string tag);
        for (int k = 0; k < 4; k++) begin
            step(tag);
            if (exp_lu) ex_valid = 1'b0;
            else if (!exp_split) break;
        end
    endtask

    task automatic idle_inputs();
        a_valid = 0; m_valid = 0; a_cls = 0; m_cls = 0; a_is_load = 0; m_is_load = 0;
        a_dst = 0; a_src1 = 0; a_src2 = 0; m_dst = 0; m_src1 = 0; m_src2 = 0;
        ex_valid = 0; ex_is_load = 0; ex_dst = 0;
    endtask

    task automatic set_dep_packet();
        a_valid = 1; a_cls = 3'd1; a_is_load = 0; a_dst = 5'd3; a_src1 = 5'd1; a_src2 = 5'd2;
        m_valid = 1; m_cls = 3'd3; m_is_load = 1; m_dst = 5'd4; m_src1 = 5'd3; m_src2 = 5'd0;
    endtask

    initial begin
        #(WATCHDOG_CYC * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset state");

        // R1: dependent packet after reset splits, ALU first; reset mid-split forgets it.
        set_dep_packet();
        step("R1 first split after reset");
        rst_n = 1'b0;
        model_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_packet("R1 split again after reset mid-split");

        // R2: every class pairing and load-flag setting, no register overlap.
        for (int ca = 0; ca < 8; ca++)
            for (int cm = 0; cm < 8; cm++)
                for (int fl = 0; fl < 4; fl++) begin
                    idle_inputs();
                    a_valid = 1; a_cls = 3'(ca); a_is_load = fl[0];
                    a_dst = 5'd1; a_src1 = 5'd2; a_src2 = 5'd3;
                    m_valid = 1; m_cls = 3'(cm); m_is_load = fl[1];
                    m_dst = 5'd4; m_src1 = 5'd5; m_src2 = 5'd6;
                    run_packet("R2 class legality");
                end

        // R3: invalid and nop slots with register overlaps issue nothing and cause no hazard.
        for (int v = 0; v < 4; v++) begin
            idle_inputs();
            set_dep_packet();
            if (v[0]) a_valid = 0; else a_cls = 3'd0;
            ex_valid = 1; ex_is_load = 1; ex_dst = 5'd1;
            run_packet("R3 empty first slot");
            idle_inputs();
            set_dep_packet();
            if (v[1]) m_valid = 0; else begin m_cls = 3'd0; m_is_load = 0; end
            run_packet("R3 empty second slot");
        end

        // R4/R5/R6/R7: register overlap sweep over registers 0..3, load and store.
        for (int code = 0; code < 4096; code++)
            for (int ex = 0; ex < 4; ex++) begin
                idle_inputs();
                a_valid = 1; a_cls = 3'd1;
                m_valid = 1;
                if (ex[1]) begin m_cls = 3'd4; m_is_load = 0; end
                else begin m_cls = 3'd3; m_is_load = 1; end
                a_dst  = 5'(code & 3);
                a_src1 = 5'((code >> 2) & 3);
                a_src2 = 5'((code >> 4) & 3);
                m_src1 = 5'((code >> 6) & 3);
                m_src2 = 5'((code >> 8) & 3);
                ex_dst = 5'((code >> 10) & 3);
                ex_valid = 1; ex_is_load = ex[0];
                run_packet("R4 R5 R6 R7 overlap sweep");
            end

        // R8: load in execute feeding only the already-issued ALU slot must not stall the second half.
        idle_inputs();
        set_dep_packet();
        step("R8 split first half");
        ex_valid = 1; ex_is_load = 1; ex_dst = 5'd1;
        step("R8 second half ignores ALU sources");
        // R8: load-use during second half holds, then the ALU is still not reissued.
        idle_inputs();
        set_dep_packet();
        step("R8 split first half again");
        ex_valid = 1; ex_is_load = 1; ex_dst = 5'd3;
        step("R8 load-use on memory half");
        ex_valid = 0;
        step("R8 memory half after bubble");

        // R9 is covered in every step through the stall/split/lu comparison.
        idle_inputs();
        step("R9 idle");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule